// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the shift and rotate stage of an integer execution pipe. Each accepted request carries a 3-bit operation code, a choice of where the shift count comes from, an operand, a width select and the incoming carry and overflow flags. One cycle later the block returns the shifted or rotated value with updated carry (CF) and overflow (OF) flags. The operand is either one byte or a full 32-bit word. Seven kinds of operation are provided: left and right rotates, left and right rotates that pass through the carry flag, a left shift, a logical right shift and an arithmetic right shift.

The count is taken from one of three places: an 8-bit immediate, a fixed count of one, or a count register input. Only the low five bits of the selected value are used. When those five bits are zero, the request passes the operand and both flags through unchanged. Outside that case, the flag rules follow the last bit moved out and a single-step overflow convention.

Top module: `shrot_unit`

## Requirements
- R1: Reset clears `out_valid`, `result`, `cf_out` and `of_out` to zero. `out_valid` equals `in_valid` of the previous cycle, and the outputs change only in the cycle after an accepted request. With `in_valid` low they hold their values.
- R2: `cnt_src` selects the count as follows: 0 takes `imm_cnt`, 1 takes the constant one, and 2 or 3 take `reg_cnt`.
- R3: The selected count is reduced to its low five bits before use, so a register count of 33 acts as a count of one.
- R4: With `wide`=1 the operand is 32 bits. With `wide`=0 only `operand[7:0]` is used and `result[31:8]` is zero.
- R5: A reduced count of zero returns the width-trimmed operand and copies `cf_in` to `cf_out` and `of_in` to `of_out`.
- R6: `op`=0 rotates left and `op`=1 rotates right, each modulo the operand width. CF becomes the result LSB for a left rotate and the result MSB for a right rotate.
- R7: `op`=2 and `op`=3 rotate left or right through CF as a (width+1)-bit quantity, with the count taken modulo width+1. An effective count of zero changes nothing.
- R8: `op`=4 and `op`=6 shift left with zero fill. CF is the last bit shifted out, and it is zero once the count exceeds the width.
- R9: `op`=5 shifts right with zero fill and `op`=7 shifts right with copies of the sign bit. CF is the last bit shifted out.
- R10: For a reduced count of one, OF is set as follows. For a left shift or rotate (ops 0, 2, 4, 6) it is the result MSB XOR the new CF. For ops 1 and 3 it is the XOR of the top two result bits. For op 5 it is the original operand MSB, and for op 7 it is 0.
- R11: For a reduced count of two or more, OF is copied from `of_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code |
| cnt_src | input | 2 | Count source select |
| imm_cnt | input | 8 | Immediate count |
| reg_cnt | input | 8 | Count register value |
| wide | input | 1 | 1 = 32-bit operand, 0 = byte operand |
| operand | input | 32 | Value to shift or rotate |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result present |
| result | output | 32 | Shifted or rotated value |
| cf_out | output | 1 | Updated carry flag |
| of_out | output | 1 | Updated overflow flag |

## Verification
Two rules can act on the same request: the five-bit count reduction and the zero-count pass-through. A register count of 32 or 64, or an immediate of 0xE0, reduces to zero and must leave the operand and both flags untouched. A count of 33 must behave exactly like a count of one, including the OF rule. The bench provokes these cases directly and also meets them in random traffic. Each result is judged against a behavioural model that moves bits one step at a time, so a byte rotate through carry by 9 must return to its starting state.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        SR_ROL     = 3'd0,
        SR_ROR     = 3'd1,
        SR_RCL     = 3'd2,
        SR_RCR     = 3'd3,
        SR_SHL     = 3'd4,
        SR_SHR     = 3'd5,
        SR_SHL_ALT = 3'd6,
        SR_SAR     = 3'd7
    } sr_op_e;

    typedef enum logic [1:0] {
        CNT_IMM     = 2'd0,
        CNT_ONE     = 2'd1,
        CNT_REG     = 2'd2,
        CNT_REG_ALT = 2'd3
    } cnt_src_e;

endpackage

// File: rtl/shrot_count_sel.sv
module shrot_count_sel
    import shrot_pkg::*;
#(
    parameter int RAW_W    = 8,
    parameter int CNT_BITS = 5
) (
    input  logic [1:0]          cnt_src,
    input  logic [RAW_W-1:0]    imm_cnt,
    input  logic [RAW_W-1:0]    reg_cnt,
    output logic [CNT_BITS-1:0] cnt
);

    logic [RAW_W-1:0] raw;
    logic             unused_raw_hi;

    always_comb begin
        case (cnt_src)
            CNT_IMM: raw = imm_cnt;
            CNT_ONE: raw = RAW_W'(1);
            default: raw = reg_cnt;
        endcase
    end

    // only the low bits of the selected count take part (R3)
    assign cnt           = raw[CNT_BITS-1:0];
    assign unused_raw_hi = ^raw[RAW_W-1:CNT_BITS];

endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int LW       = 8,
    parameter int CNT_BITS = 5
) (
    input  logic [2:0]          op,
    input  logic [CNT_BITS-1:0] cnt,
    input  logic [LW-1:0]       x,
    input  logic                cf_in,
    input  logic                of_in,
    output logic [LW-1:0]       res,
    output logic                cf,
    output logic                of
);

    localparam int RCW   = LW + 1;
    localparam int EXT_W = LW + (1 << CNT_BITS);

    logic [2*LW-1:0]  rot_l, rot_r;
    logic [RCW-1:0]   rc_t;
    logic [2*RCW-1:0] rc_l, rc_r;
    logic [EXT_W-1:0] shl_e;
    logic [LW:0]      shr_e, sar_e;
    int unsigned      rot_amt, rc_amt;
    logic             unused_lane_bits;

    always_comb begin
        rot_amt = 32'(cnt) % 32'(LW);
        rc_amt  = 32'(cnt) % 32'(RCW);
        rot_l   = {x, x} << rot_amt;
        rot_r   = {x, x} >> rot_amt;
        rc_t    = {cf_in, x};
        rc_l    = {rc_t, rc_t} << rc_amt;
        rc_r    = {rc_t, rc_t} >> rc_amt;
        shl_e   = EXT_W'(x) << cnt;
        shr_e   = {x, 1'b0} >> cnt;
        sar_e   = $signed({x, 1'b0}) >>> cnt;
    end

    always_comb begin
        res = x;
        cf  = cf_in;
        of  = of_in;
        if (cnt != '0) begin
            case (op)
                SR_ROL: begin
                    res = rot_l[2*LW-1:LW];
                    cf  = rot_l[LW];
                end
                SR_ROR: begin
                    res = rot_r[LW-1:0];
                    cf  = rot_r[LW-1];
                end
                SR_RCL: begin
                    if (rc_amt != 0) {cf, res} = rc_l[2*RCW-1:RCW];
                end
                SR_RCR: begin
                    if (rc_amt != 0) {cf, res} = rc_r[RCW-1:0];
                end
                SR_SHR: begin
                    res = shr_e[LW:1];
                    cf  = shr_e[0];
                end
                SR_SAR: begin
                    res = sar_e[LW:1];
                    cf  = sar_e[0];
                end
                default: begin
                    res = shl_e[LW-1:0];
                    cf  = shl_e[LW];
                end
            endcase
            if (cnt == CNT_BITS'(1)) begin
                case (op)
                    SR_ROR, SR_RCR: of = res[LW-1] ^ res[LW-2];
                    SR_SHR:         of = x[LW-1];
                    SR_SAR:         of = 1'b0;
                    default:        of = res[LW-1] ^ cf;
                endcase
            end
        end
    end

    assign unused_lane_bits = ^{rot_l[LW-1:0], rot_r[2*LW-1:LW], rc_l[RCW-1:0],
                                rc_r[2*RCW-1:RCW], shl_e[EXT_W-1:LW+1]};

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int W        = 32,
    parameter int BW       = 8,
    parameter int RAW_W    = 8,
    parameter int CNT_BITS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic [1:0]       cnt_src,
    input  logic [RAW_W-1:0] imm_cnt,
    input  logic [RAW_W-1:0] reg_cnt,
    input  logic             wide,
    input  logic [W-1:0]     operand,
    input  logic             cf_in,
    input  logic             of_in,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             cf_out,
    output logic             of_out
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         cf;
        logic         of;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_BITS-1:0] cnt;
    logic [1:0][W-1:0]   lane_res;
    logic [1:0]          lane_cf;
    logic [1:0]          lane_of;

    shrot_count_sel #(
        .RAW_W    (RAW_W),
        .CNT_BITS (CNT_BITS)
    ) u_cnt (
        .cnt_src (cnt_src),
        .imm_cnt (imm_cnt),
        .reg_cnt (reg_cnt),
        .cnt     (cnt)
    );

    // lane 0 handles the byte operand, lane 1 the full word
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? BW : W;
        logic [LW-1:0] lres;
        shrot_lane #(
            .LW       (LW),
            .CNT_BITS (CNT_BITS)
        ) u_lane (
            .op    (op),
            .cnt   (cnt),
            .x     (operand[LW-1:0]),
            .cf_in (cf_in),
            .of_in (of_in),
            .res   (lres),
            .cf    (lane_cf[g]),
            .of    (lane_of[g])
        );
        assign lane_res[g] = W'(lres);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = lane_res[wide];
            st_d.cf  = lane_cf[wide];
            st_d.of  = lane_of[wide];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cf_out    = st_q.cf;
    assign of_out    = st_q.of;

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int W        = 32,
    parameter int BW       = 8,
    parameter int CNT_BITS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2:0]          op,
    input logic [1:0]          cnt_src,
    input logic [CNT_BITS-1:0] imm_lo,
    input logic [CNT_BITS-1:0] reg_lo,
    input logic                wide,
    input logic [W-1:0]        operand,
    input logic                cf_in,
    input logic                of_in,
    input logic                out_valid,
    input logic [W-1:0]        result,
    input logic                cf_out,
    input logic                of_out
);

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(cf_out) && $stable(of_out));

    p_byte_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !wide |=> result[W-1:BW] == '0);

    p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cnt_src == 2'd0 && imm_lo == '0 |=>
            cf_out == $past(cf_in) && of_out == $past(of_in) &&
            result == $past(wide ? operand : W'(operand[BW-1:0])));

    p_reg_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cnt_src[1] && reg_lo == '0 |=> cf_out == $past(cf_in));

    p_shl_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 3'd4 && cnt_src == 2'd1 |=> !result[0]);

    p_sar_of_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 3'd7 && cnt_src == 2'd1 |=> !of_out);

    p_shr_of_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 3'd5 && cnt_src == 2'd1 |=>
            of_out == $past(wide ? operand[W-1] : operand[BW-1]));

endmodule

bind shrot_unit shrot_unit_chk #(
    .W        (W),
    .BW       (BW),
    .CNT_BITS (CNT_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .cnt_src   (cnt_src),
    .imm_lo    (imm_cnt[CNT_BITS-1:0]),
    .reg_lo    (reg_cnt[CNT_BITS-1:0]),
    .wide      (wide),
    .operand   (operand),
    .cf_in     (cf_in),
    .of_in     (of_in),
    .out_valid (out_valid),
    .result    (result),
    .cf_out    (cf_out),
    .of_out    (of_out)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  cnt_src = '0;
    logic [7:0]  imm_cnt = '0;
    logic [7:0]  reg_cnt = '0;
    logic        wide = 1'b0;
    logic [31:0] operand = '0;
    logic        cf_in = 1'b0;
    logic        of_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        cf_out;
    logic        of_out;

    int total = 0;
    int failed = 0;

    logic        exp_vld = 1'b0;
    logic [31:0] exp_res = '0;
    logic        exp_cf = 1'b0;
    logic        exp_of = 1'b0;
    string       exp_tag = "R1";

    always #5 clk = ~clk;

    shrot_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .cnt_src   (cnt_src),
        .imm_cnt   (imm_cnt),
        .reg_cnt   (reg_cnt),
        .wide      (wide),
        .operand   (operand),
        .cf_in     (cf_in),
        .of_in     (of_in),
        .out_valid (out_valid),
        .result    (result),
        .cf_out    (cf_out),
        .of_out    (of_out)
    );

    // behavioural model: moves bits one position per step
    function automatic void model(input logic [2:0] o, input logic [1:0] s,
                                  input logic [7:0] im, input logic [7:0] rc,
                                  input logic wd, input logic [31:0] x,
                                  input logic cfi, input logic ofi,
                                  output logic [31:0] r, output logic cf,
                                  output logic of, output string tag);
        int n;
        int c;
        logic [31:0] m;
        logic [31:0] v;
        logic [7:0] raw;
        logic bit_out;
        n   = wd ? 32 : 8;
        m   = wd ? 32'hFFFF_FFFF : 32'h0000_00FF;
        raw = (s == 2'd0) ? im : (s == 2'd1) ? 8'd1 : rc;   // R2
        c   = int'(raw[4:0]);                                // R3
        v   = x & m;                                         // R4
        cf  = cfi;
        of  = ofi;                                           // R11 unless count is one
        case (o)
            3'd0, 3'd1: tag = "R6";
            3'd2, 3'd3: tag = "R7";
            3'd4, 3'd6: tag = "R8";
            default:    tag = "R9";
        endcase
        if (c == 0) begin
            r   = v;
            tag = "R5";
            return;
        end
        for (int i = 0; i < c; i++) begin
            case (o)
                3'd0: begin bit_out = v[n-1]; v = ((v << 1) | 32'(bit_out)) & m; cf = bit_out; end
                3'd1: begin bit_out = v[0]; v = (v >> 1) | (32'(bit_out) << (n-1)); cf = bit_out; end
                3'd2: begin bit_out = v[n-1]; v = ((v << 1) | 32'(cf)) & m; cf = bit_out; end
                3'd3: begin bit_out = v[0]; v = (v >> 1) | (32'(cf) << (n-1)); cf = bit_out; end
                3'd5: begin bit_out = v[0]; v = v >> 1; cf = bit_out; end
                3'd7: begin bit_out = v[0]; v = (v >> 1) | (32'(v[n-1]) << (n-1)); cf = bit_out; end
                default: begin bit_out = v[n-1]; v = (v << 1) & m; cf = bit_out; end
            endcase
        end
        r = v;
        if (c == 1) begin
            tag = "R10";
            case (o)
                3'd1, 3'd3: of = v[n-1] ^ v[n-2];
                3'd5:       of = x[n-1];
                3'd7:       of = 1'b0;
                default:    of = v[n-1] ^ cf;
            endcase
        end else if (raw > 8'd31) begin
            tag = "R3";
        end
    endfunction

    task automatic compare();
        total++;
        if (out_valid !== exp_vld || result !== exp_res ||
            cf_out !== exp_cf || of_out !== exp_of) begin
            failed++;
            $display("FAIL %s: got vld=%0b res=%h cf=%0b of=%0b, expected vld=%0b res=%h cf=%0b of=%0b",
                     exp_tag, out_valid, result, cf_out, of_out,
                     exp_vld, exp_res, exp_cf, exp_of);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] o, input logic [1:0] s,
                        input logic [7:0] im, input logic [7:0] rc, input logic wd,
                        input logic [31:0] x, input logic cfi, input logic ofi);
        @(negedge clk);
        compare();
        in_valid = v;
        op       = o;
        cnt_src  = s;
        imm_cnt  = im;
        reg_cnt  = rc;
        wide     = wd;
        operand  = x;
        cf_in    = cfi;
        of_in    = ofi;
        exp_vld  = v;
        if (v) model(o, s, im, rc, wd, x, cfi, ofi, exp_res, exp_cf, exp_of, exp_tag);
        else   exp_tag = "R1";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();                   // R1 reset state
        rst_n = 1'b1;
        // R2 count sources
        step(1, 3'd0, 2'd0, 8'd3, 8'd0, 1, 32'h8000_0001, 0, 0);
        step(1, 3'd1, 2'd1, 8'd7, 8'd7, 1, 32'h0000_0003, 0, 1);
        step(1, 3'd4, 2'd2, 8'd0, 8'd2, 0, 32'h0000_00C1, 1, 1);
        step(1, 3'd5, 2'd3, 8'd0, 8'd4, 1, 32'hF000_0000, 0, 0);
        // R3 reduction: 33 acts as one, 0xE0 and 64 as zero
        step(1, 3'd4, 2'd2, 8'd0, 8'd33, 0, 32'h0000_0080, 0, 1);
        step(1, 3'd0, 2'd0, 8'hE0, 8'd0, 1, 32'h1234_5678, 1, 1);
        step(1, 3'd3, 2'd2, 8'd0, 8'd64, 0, 32'hFFFF_FF5A, 0, 1);
        // R4 byte mode ignores upper operand bits
        step(1, 3'd1, 2'd0, 8'd4, 8'd0, 0, 32'hDEAD_BE3C, 0, 0);
        // R5 zero count
        step(1, 3'd7, 2'd0, 8'd0, 8'd0, 0, 32'hAAAA_AA81, 1, 0);
        // R6 rotates
        step(1, 3'd0, 2'd0, 8'd8, 8'd0, 0, 32'h0000_0081, 0, 0);
        step(1, 3'd1, 2'd0, 8'd31, 8'd0, 1, 32'h8000_0000, 0, 0);
        // R7 rotates through carry, byte count 9 is a full turn
        step(1, 3'd2, 2'd0, 8'd9, 8'd0, 0, 32'h0000_00A5, 1, 0);
        step(1, 3'd2, 2'd0, 8'd10, 8'd0, 0, 32'h0000_00A5, 1, 0);
        step(1, 3'd3, 2'd0, 8'd31, 8'd0, 1, 32'h0F0F_0F0F, 1, 1);
        // R8 left shift past the width, both codes
        step(1, 3'd4, 2'd0, 8'd8, 8'd0, 0, 32'h0000_0001, 0, 1);
        step(1, 3'd6, 2'd0, 8'd9, 8'd0, 0, 32'h0000_00FF, 1, 1);
        // R9 right shifts
        step(1, 3'd7, 2'd0, 8'd20, 8'd0, 0, 32'h0000_0080, 0, 0);
        step(1, 3'd5, 2'd0, 8'd8, 8'd0, 0, 32'h0000_0080, 0, 0);
        step(1, 3'd7, 2'd0, 8'd3, 8'd0, 1, 32'h8000_0010, 0, 1);
        // R10 count of one on every code; R11 follows with count two
        for (int k = 0; k < 8; k++) begin
            step(1, 3'(k), 2'd1, 8'd0, 8'd0, 0, 32'h0000_00C0, 1, 1);
            step(1, 3'(k), 2'd1, 8'd0, 8'd0, 1, 32'h4000_0001, 0, 1);
            step(1, 3'(k), 2'd0, 8'd2, 8'd0, 1, 32'hC000_0001, 1, 1);
        end
        // R1 idle hold
        step(0, 3'd0, 2'd1, 8'd0, 8'd0, 1, 32'hFFFF_FFFF, 1, 1);
        step(0, 3'd4, 2'd1, 8'd0, 8'd0, 0, 32'h0, 0, 0);
        // random traffic
        for (int k = 0; k < 800; k++) begin
            step(($urandom % 5) != 0, 3'($urandom), 2'($urandom), 8'($urandom),
                 8'($urandom), 1'($urandom), $urandom, 1'($urandom), 1'($urandom));
        end
        step(0, 3'd0, 2'd0, 8'd0, 8'd0, 0, 32'h0, 0, 0);
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule